// File: doc/BRIEF.md
# ARINC Receive Word Acceptance Filter

This block sits between a serial ARINC 429 receiver and its receive buffer. Each time the receiver signals that a complete 32-bit word has been assembled, the filter decides whether to pass that word on. A word that passes is presented on the output together with a one-cycle load strobe. A word that fails is dropped silently.

Two checks decide the outcome, and each has its own enable. The first looks up the 8-bit label in a 16-entry table. The second compares the two source/destination identifier bits with a configured pair. Any check that is enabled must pass. The host loads the table one entry per cycle through an index/data/write-enable port. Unused entries are meant to hold copies of a wanted label, so entries have no valid bit.

Top module: `arinc_label_filter`

## Requirements
- R1: During and right after reset, `load_o` is 0, `word_o` is 0 and every table entry holds 00 hex.
- R2: When `eos_i` is high in a cycle and every enabled check passes, `load_o` is high for exactly the next cycle and `word_o` equals the `word_i` sampled with `eos_i`.
- R3: When `lbl_en_i` is 0, the label check passes for any label.
- R4: When `lbl_en_i` is 1, the label check passes only if some table entry equals `word_i[7:0]`. A match at the first or the last index counts the same as any other.
- R5: When `sdi_en_i` is 1, `word_i[9]` must equal `sdi_exp_i[1]` and `word_i[8]` must equal `sdi_exp_i[0]`. When `sdi_en_i` is 0, this check always passes.
- R6: When both checks are enabled, a word is accepted only if both pass.
- R7: A rejected word leaves `load_o` low and `word_o` unchanged from the last accepted word.
- R8: Label value 00 hex is matched exactly like any other label value.
- R9: A table write in the same cycle as `eos_i` does not affect that comparison. It takes effect from the next comparison onward.
- R10: `load_o` is never high unless `eos_i` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eos_i | input | 1 | End-of-word pulse from the receiver |
| word_i | input | 32 | Received word, label in bits 7:0 |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | 4 | Table entry index |
| tbl_data_i | input | 8 | Label value to store |
| lbl_en_i | input | 1 | Enable the label check |
| sdi_en_i | input | 1 | Enable the identifier bit check |
| sdi_exp_i | input | 2 | Expected values of word bits 9:8 |
| load_o | output | 1 | One-cycle strobe: accepted word |
| word_o | output | 32 | Last accepted word |

## Verification
- **Unfiltered words:** the bench sends arbitrary words with both checks off. This confirms the pass-through path and the one-cycle latency.
- **Label check:** the table is filled with distinct labels. Labels at index 0 and index 15 must be accepted and an absent label rejected, which shows that every entry is compared and that misses are dropped.
- **Label 00 hex:** it is sent before and after being written into the table, which separates a true comparison from any zero shortcut.
- **Identifier check:** all four values of bits 9:8 are tried against one configured pair, which exposes swapped or ignored bits.
- **Both checks together:** mixed pass/fail combinations show that the two checks are combined with AND.
- **Write and compare in one cycle:** a write that coincides with `eos_i` shows that the comparison uses the old table contents.

// File: rtl/arinc_filt_pkg.sv
package arinc_filt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LBL_W   = 8;
  localparam int unsigned TBL_N   = 16;
  localparam int unsigned SDI_LSB = 8;
  localparam int unsigned TBL_IW  = $clog2(TBL_N);
endpackage

// File: rtl/arinc_label_table.sv
module arinc_label_table #(
  parameter int unsigned N  = 16,
  parameter int unsigned LW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [LW-1:0] data_i,
  input  logic [LW-1:0] lbl_i,
  output logic          hit_o
);
  logic [LW-1:0] ent_q [N];
  logic [N-1:0]  match;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ent_q[g] <= '0;
      else if (we_i && idx_i == IW'(g))     ent_q[g] <= data_i;
    end
    // compare against pre-write contents
    assign match[g] = (ent_q[g] == lbl_i);
  end

  assign hit_o = |match;

  p_tbl_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(idx_i)] == $past(data_i));
endmodule

// File: rtl/arinc_sdi_check.sv
module arinc_sdi_check #(
  parameter int unsigned WW  = 32,
  parameter int unsigned POS = 8
) (
  input  logic          en_i,
  input  logic [1:0]    exp_i,
  input  logic [WW-1:0] word_i,
  output logic          pass_o
);
  logic [1:0] sdi;
  assign sdi    = word_i[POS+1:POS];
  assign pass_o = !en_i || (sdi == exp_i);
endmodule

// File: rtl/arinc_label_filter.sv
module arinc_label_filter
  import arinc_filt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eos_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tbl_we_i,
  input  logic [TBL_IW-1:0] tbl_idx_i,
  input  logic [LBL_W-1:0]  tbl_data_i,
  input  logic              lbl_en_i,
  input  logic              sdi_en_i,
  input  logic [1:0]        sdi_exp_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);
  logic lbl_hit, sdi_pass, accept;
  logic load_q;
  logic [WORD_W-1:0] word_q;

  arinc_label_table #(.N(TBL_N), .LW(LBL_W)) i_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .idx_i  (tbl_idx_i),
    .data_i (tbl_data_i),
    .lbl_i  (word_i[LBL_W-1:0]),
    .hit_o  (lbl_hit)
  );

  arinc_sdi_check #(.WW(WORD_W), .POS(SDI_LSB)) i_sdi (
    .en_i   (sdi_en_i),
    .exp_i  (sdi_exp_i),
    .word_i (word_i),
    .pass_o (sdi_pass)
  );

  assign accept = eos_i && (!lbl_en_i || lbl_hit) && sdi_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      word_q <= '0;
    end else begin
      load_q <= accept;
      if (accept) word_q <= word_i;
    end
  end

  assign load_o = load_q;
  assign word_o = word_q;

  p_load_needs_eos_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(eos_i));
  p_load_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> word_o == $past(word_i));
  p_reject_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> $stable(word_o));
  p_sdi_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && $past(sdi_en_i)) |-> $past(word_i[SDI_LSB+1:SDI_LSB]) == $past(sdi_exp_i));
  p_no_filter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !lbl_en_i && !sdi_en_i) |=> load_o);
endmodule

// File: tb/test_arinc_label_filter.sv
module test_arinc_label_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eos = 1'b0;
  logic [31:0] word = '0;
  logic        we = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  data = '0;
  logic        lbl_en = 1'b0;
  logic        sdi_en = 1'b0;
  logic [1:0]  sdi_exp = '0;
  logic        load;
  logic [31:0] wout;

  int total = 0;
  int bad = 0;
  logic [31:0] last_acc = '0;
  bit done = 0;

  always #2 clk = ~clk;

  arinc_label_filter i_arinc_label_filter (
    .clk_i(clk), .rst_ni(rst_n), .eos_i(eos), .word_i(word),
    .tbl_we_i(we), .tbl_idx_i(idx), .tbl_data_i(data),
    .lbl_en_i(lbl_en), .sdi_en_i(sdi_en), .sdi_exp_i(sdi_exp),
    .load_o(load), .word_o(wout));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; idx = i; data = d;
    @(negedge clk);
    we = 1'b0;
    chk("R10 idle", {31'b0, load}, 32'd0);
  endtask

  // send one word, optionally with a coincident table write
  task automatic send(input string req, input logic [31:0] w, input bit exp_acc,
                      input bit do_wr = 0, input logic [3:0] wi = '0, input logic [7:0] wd = '0);
    @(negedge clk);
    word = w; eos = 1'b1;
    if (do_wr) begin we = 1'b1; idx = wi; data = wd; end
    @(negedge clk);
    eos = 1'b0; we = 1'b0; word = 32'hDEAD_BEEF;
    if (exp_acc) last_acc = w;
    chk({req, " load"}, {31'b0, load}, {31'b0, exp_acc});
    chk({req, " word"}, wout, last_acc);
    @(negedge clk);
    chk("R10 one-cycle strobe", {31'b0, load}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 load", {31'b0, load}, 32'd0);
    chk("R1 word", wout, 32'd0);
    lbl_en = 1'b1; sdi_en = 1'b0;
    send("R1 table zeroed", 32'h1234_5600, 1);
    send("R1 nonzero label miss", 32'h1234_5601, 0);
  endtask

  task automatic t_nofilter();
    lbl_en = 1'b0; sdi_en = 1'b0;
    send("R3 any label", 32'hA5A5_5AC3, 1);
    send("R2 pass", 32'h0000_03FF, 1);
    send("R3 other", 32'h7FFF_FF81, 1);
  endtask

  task automatic t_label();
    for (int i = 0; i < 16; i++) wr(4'(i), 8'h20 + 8'(i));
    lbl_en = 1'b1; sdi_en = 1'b0;
    send("R4 first entry", 32'h0101_0120, 1);
    send("R4 last entry", 32'h0202_022F, 1);
    send("R4 middle entry", 32'h0303_0327, 1);
    send("R7 absent label", 32'h0404_0440, 0);
    send("R7 absent label 2", 32'h0505_051F, 0);
  endtask

  task automatic t_zero();
    lbl_en = 1'b1; sdi_en = 1'b0;
    send("R8 zero absent", 32'h0606_0600, 0);
    wr(4'd5, 8'h00);
    send("R8 zero stored", 32'h0707_0700, 1);
    wr(4'd5, 8'h25);
  endtask

  task automatic t_sdi();
    lbl_en = 1'b0; sdi_en = 1'b1; sdi_exp = 2'b10;
    send("R5 bits 10", 32'h0000_0211, 1);
    send("R5 bits 01", 32'h0000_0111, 0);
    send("R5 bits 11", 32'h0000_0311, 0);
    send("R5 bits 00", 32'h0000_0011, 0);
    sdi_en = 1'b0;
    send("R5 disabled", 32'h0000_0111, 1);
  endtask

  task automatic t_both();
    lbl_en = 1'b1; sdi_en = 1'b1; sdi_exp = 2'b01;
    send("R6 label ok sdi bad", 32'h0000_0221, 0);
    send("R6 label bad sdi ok", 32'h0000_0150, 0);
    send("R6 both ok", 32'h0000_0121, 1);
  endtask

  task automatic t_same_cycle();
    lbl_en = 1'b1; sdi_en = 1'b0;
    wr(4'd3, 8'h55);
    send("R9 old entry used", 32'h0000_0055, 1, 1, 4'd3, 8'h66);
    send("R9 old label gone", 32'h0000_0055, 0);
    send("R9 new label", 32'h0000_0066, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nofilter();
    t_label();
    t_zero();
    t_sdi();
    t_both();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule